// File: doc/BRIEF.md
# Dual-Lane Fixed-Point MAC Unit

This block provides two independent fixed-point arithmetic units for a DSP datapath. Each unit can accept one operation per clock cycle: a fractional (Q.31-scaled) multiply-add, a two-lane dot product added to a 64-bit accumulator, a pair of fractional multiply-adds on packed lanes, or an arithmetic right shift of a 64-bit value with optional rounding. Both units may issue in the same cycle. Each has its own operands, opcode and valid bit.

A 64-bit operand packs two signed 32-bit lanes. Lane 0 is in bits 31:0 and lane 1 is in bits 63:32. Every operation completes with a fixed latency of two clock cycles. The result comes back with a valid bit and the opcode that produced it, so the surrounding datapath can route it without tracking timing of its own. All sums wrap in two's complement.

Top module: `dual_mac_unit`

## Requirements
- R1: While rst_n is low, both bits of out_vld are 0.
- R2: Opcode 0 (fractional multiply-add) computes a[31:0] + ((b[31:0]*c[31:0]) >>> 31). The operands are signed 32-bit values and the product is taken at full 64-bit precision. The sum is truncated to 32 bits and sign-extended into the 64-bit result.
- R3: Opcode 1 (dot product) returns a + b[63:32]*c[63:32] + b[31:0]*c[31:0]. The lanes are signed and the sum wraps at 64 bits.
- R4: Opcode 2 (paired multiply-add) applies the R2 computation to each lane independently. Lane 0 of the result is in bits 31:0 and lane 1 is in bits 63:32. Lane 1 uses a[63:32], b[63:32] and c[63:32].
- R5: Opcode 3 (shift) with rounding off returns a arithmetically shifted right by sh, with sh in the range 0..63.
- R6: Opcode 3 with rounding on and nonzero sh adds 1 << (sh-1) to a, wrapping at 64 bits, before the arithmetic shift. When sh is 0 the value passes through unchanged, whatever the rounding input.
- R7: out_vld and out_op of a unit equal that unit's in_vld and in_op from exactly two cycles earlier. A unit accepts a new operation every cycle.
- R8: The two units operate independently in the same cycle. An operation on one unit neither changes nor depends on the other unit's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | NU | Per-unit operation valid |
| in_op | input | NU x 2 | Per-unit opcode (0 madd, 1 dot, 2 paired madd, 3 shift) |
| in_a | input | NU x 64 | Addend, accumulator or value to shift |
| in_b | input | NU x 64 | First packed multiplicand |
| in_c | input | NU x 64 | Second packed multiplicand |
| in_sh | input | NU x 6 | Shift amount |
| in_rnd | input | NU | Rounding enable for the shift |
| out_vld | output | NU | Per-unit result valid, two cycles after issue |
| out_op | output | NU x 2 | Opcode of the returning result |
| out_res | output | NU x 64 | Result |

## Verification
The fractional multiply-add is tried with positive halves, with mixed signs, and with both operands at the most negative value. These cases separate a correct 31-bit product shift from an off-by-one shift, and expose sign-handling faults and a failure to wrap at 32 bits. The dot product uses lane values that differ from each other, so a swapped or dropped lane shows up in the result. The paired form uses lanes of opposite sign to detect leakage from one lane into the other. The shift is tried on negative odd values, with and without rounding and at zero shift, to separate truncation from rounding. Back-to-back issue and simultaneous issue on both units show the tagging and that the units do not interfere.

// File: rtl/dual_mac_unit.sv
module dual_mac_unit #(
  parameter int NU  = 2,
  parameter int DW  = 32,
  parameter int XW  = 2 * DW,
  parameter int SHW = $clog2(XW)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NU-1:0]           in_vld,
  input  logic [NU-1:0][1:0]      in_op,
  input  logic [NU-1:0][XW-1:0]   in_a,
  input  logic [NU-1:0][XW-1:0]   in_b,
  input  logic [NU-1:0][XW-1:0]   in_c,
  input  logic [NU-1:0][SHW-1:0]  in_sh,
  input  logic [NU-1:0]           in_rnd,
  output logic [NU-1:0]           out_vld,
  output logic [NU-1:0][1:0]      out_op,
  output logic [NU-1:0][XW-1:0]   out_res
);

  localparam logic [1:0] OP_MADD = 2'd0;
  localparam logic [1:0] OP_DOT  = 2'd1;
  localparam logic [1:0] OP_PAIR = 2'd2;
  localparam logic [1:0] OP_SHR  = 2'd3;

  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic signed [XW-1:0] b0, c0, b1, c1;
    logic                 s1_vld, s1_rnd;
    logic [1:0]           s1_op;
    logic [XW-1:0]        s1_a, s1_p0, s1_p1;
    logic [SHW-1:0]       s1_sh;
    logic [DW-1:0]        lane0, lane1;
    logic [XW-1:0]        bias, res;

    assign b0 = {{DW{in_b[u][DW-1]}}, in_b[u][DW-1:0]};
    assign c0 = {{DW{in_c[u][DW-1]}}, in_c[u][DW-1:0]};
    assign b1 = {{DW{in_b[u][XW-1]}}, in_b[u][XW-1:DW]};
    assign c1 = {{DW{in_c[u][XW-1]}}, in_c[u][XW-1:DW]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_vld <= 1'b0;
      else        s1_vld <= in_vld[u];
    end

    always_ff @(posedge clk) begin
      s1_op  <= in_op[u];
      s1_a   <= in_a[u];
      s1_sh  <= in_sh[u];
      s1_rnd <= in_rnd[u];
      s1_p0  <= b0 * c0;
      s1_p1  <= b1 * c1;
    end

    assign lane0 = s1_a[DW-1:0]  + s1_p0[2*DW-2:DW-1];
    assign lane1 = s1_a[XW-1:DW] + s1_p1[2*DW-2:DW-1];
    assign bias  = (s1_rnd && s1_sh != '0) ? (XW'(1) << (s1_sh - SHW'(1))) : '0;

    always_comb begin
      unique case (s1_op)
        OP_MADD: res = {{DW{lane0[DW-1]}}, lane0};
        OP_DOT:  res = s1_a + s1_p0 + s1_p1;
        OP_PAIR: res = {lane1, lane0};
        OP_SHR:  res = XW'($signed(s1_a + bias) >>> s1_sh);
        default: res = '0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_vld[u] <= 1'b0;
      else        out_vld[u] <= s1_vld;
    end

    always_ff @(posedge clk) begin
      out_op[u]  <= s1_op;
      out_res[u] <= res;
    end
  end

endmodule

// File: rtl/dual_mac_unit_chk.sv
module dual_mac_unit_chk #(
  parameter int NU  = 2,
  parameter int DW  = 32,
  parameter int XW  = 2 * DW,
  parameter int SHW = $clog2(XW)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NU-1:0]          in_vld,
  input logic [NU-1:0][1:0]     in_op,
  input logic [NU-1:0][XW-1:0]  in_a,
  input logic [NU-1:0][SHW-1:0] in_sh,
  input logic [NU-1:0]          out_vld,
  input logic [NU-1:0][1:0]     out_op,
  input logic [NU-1:0][XW-1:0]  out_res
);

  logic [1:0] since_rst;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign warm = (since_rst >= 2'd2);

  always @(posedge clk) begin
    // R1
    if (!rst_n) reset_quiet_chk: assert (out_vld == '0);
  end

  for (genvar u = 0; u < NU; u++) begin : g_chk
    // R7
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> out_vld[u] == $past(in_vld[u], 2));

    // R7
    op_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_vld[u]) |-> out_op[u] == $past(in_op[u], 2));

    // R2
    madd_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[u] && out_op[u] == 2'd0) |-> out_res[u][XW-1:DW] == {DW{out_res[u][DW-1]}});

    // R6
    shift_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_vld[u] && out_op[u] == 2'd3 && $past(in_sh[u], 2) == '0)
        |-> out_res[u] == $past(in_a[u], 2));
  end

endmodule

bind dual_mac_unit dual_mac_unit_chk #(.NU(NU), .DW(DW), .XW(XW), .SHW(SHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op), .in_a(in_a),
  .in_sh(in_sh), .out_vld(out_vld), .out_op(out_op), .out_res(out_res)
);

// File: tb/dual_mac_unit_bench.sv
module dual_mac_unit_bench;
  localparam int NU = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NU-1:0]        in_vld = '0;
  logic [NU-1:0][1:0]   in_op = '0;
  logic [NU-1:0][63:0]  in_a = '0, in_b = '0, in_c = '0;
  logic [NU-1:0][5:0]   in_sh = '0;
  logic [NU-1:0]        in_rnd = '0;
  logic [NU-1:0]        out_vld;
  logic [NU-1:0][1:0]   out_op;
  logic [NU-1:0][63:0]  out_res;

  int n_chk = 0, n_bad = 0;

  dual_mac_unit u_dual_mac_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op), .in_a(in_a),
    .in_b(in_b), .in_c(in_c), .in_sh(in_sh), .in_rnd(in_rnd),
    .out_vld(out_vld), .out_op(out_op), .out_res(out_res)
  );

  always #5 clk = ~clk;

  function automatic longint q31(longint a, longint b, longint c);
    int r;
    r = int'(a) + int'((longint'(int'(b)) * longint'(int'(c))) >>> 31);
    return longint'(r);
  endfunction

  function automatic logic [63:0] m_madd(logic [63:0] a, b, c);
    return q31(longint'(a[31:0]), longint'(b[31:0]), longint'(c[31:0]));
  endfunction

  function automatic logic [63:0] m_dot(logic [63:0] a, b, c);
    return a + longint'(int'(b[63:32])) * longint'(int'(c[63:32]))
             + longint'(int'(b[31:0])) * longint'(int'(c[31:0]));
  endfunction

  function automatic logic [63:0] m_pair(logic [63:0] a, b, c);
    logic [63:0] l0, l1;
    l0 = q31(longint'(a[31:0]), longint'(b[31:0]), longint'(c[31:0]));
    l1 = q31(longint'(a[63:32]), longint'(b[63:32]), longint'(c[63:32]));
    return {l1[31:0], l0[31:0]};
  endfunction

  function automatic logic [63:0] m_shr(logic [63:0] a, int sh, bit rnd);
    longint v;
    v = longint'(a);
    if (rnd && sh != 0) v = v + (longint'(1) << (sh - 1));
    return v >>> sh;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(int u, logic [1:0] op, logic [63:0] a, b, c, logic [5:0] sh, bit rnd);
    in_vld[u] = 1'b1; in_op[u] = op; in_a[u] = a; in_b[u] = b; in_c[u] = c;
    in_sh[u] = sh; in_rnd[u] = rnd;
  endtask

  task automatic run1(string req, int u, logic [1:0] op, logic [63:0] a, b, c,
                      logic [5:0] sh, bit rnd, logic [63:0] exp);
    @(negedge clk);
    launch(u, op, a, b, c, sh, rnd);
    @(posedge clk); #1 in_vld = '0;
    @(posedge clk); #1;
    check(req, 64'(out_vld[u]), 64'd1);
    check(req, 64'(out_op[u]), 64'(op));
    check(req, out_res[u], exp);
  endtask

  task automatic t_reset();
    #1;
    check("R1", 64'(out_vld), 64'd0);
    repeat (3) @(posedge clk);
    #1 check("R1", 64'(out_vld), 64'd0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_madd();
    logic [63:0] a, b, c;
    a = 64'h10000000; b = 64'h40000000; c = 64'h40000000;
    run1("R2", 0, 2'd0, a, b, c, 0, 0, 64'h30000000);
    a = 64'hFFFFFFFF_00000005; b = 64'h0000_0000_C0000000; c = 64'h20000000;
    run1("R2", 1, 2'd0, a, b, c, 0, 0, m_madd(a, b, c));
    a = 64'h7FFFFFFF; b = 64'h80000000; c = 64'h80000000;
    run1("R2", 0, 2'd0, a, b, c, 0, 0, m_madd(a, b, c));
  endtask

  task automatic t_dot();
    logic [63:0] a, b, c;
    a = 64'd1000; b = {32'd3, 32'd5}; c = {32'd7, 32'd11};
    run1("R3", 0, 2'd1, a, b, c, 0, 0, 64'd1076);
    a = 64'h7FFFFFFF_FFFFFFFF; b = {32'h80000000, 32'hFFFFFFFE}; c = {32'h80000000, 32'h12345678};
    run1("R3", 1, 2'd1, a, b, c, 0, 0, m_dot(a, b, c));
  endtask

  task automatic t_pair();
    logic [63:0] a, b, c;
    a = {32'h00000100, 32'hFFFFFF00}; b = {32'hC0000000, 32'h40000000}; c = {32'h40000000, 32'h60000000};
    run1("R4", 0, 2'd2, a, b, c, 0, 0, m_pair(a, b, c));
    a = {32'h7FFFFFFF, 32'd0}; b = {32'h7FFFFFFF, 32'h80000000}; c = {32'h7FFFFFFF, 32'h7FFFFFFF};
    run1("R4", 1, 2'd2, a, b, c, 0, 0, m_pair(a, b, c));
  endtask

  task automatic t_shift();
    run1("R5", 0, 2'd3, -64'sd7, 0, 0, 6'd1, 0, -64'sd4);
    run1("R5", 1, 2'd3, 64'h80000000_00000000, 0, 0, 6'd63, 0, 64'hFFFFFFFF_FFFFFFFF);
    run1("R6", 0, 2'd3, -64'sd7, 0, 0, 6'd1, 1, -64'sd3);
    run1("R6", 1, 2'd3, 64'd7, 0, 0, 6'd1, 1, 64'd4);
    run1("R6", 0, 2'd3, 64'h1234_5678_9ABC_DEF1, 0, 0, 6'd0, 1, 64'h1234_5678_9ABC_DEF1);
    run1("R6", 1, 2'd3, 64'h0000_0001_8000_0000, 0, 0, 6'd32, 1, m_shr(64'h0000_0001_8000_0000, 32, 1));
  endtask

  task automatic t_pipe();
    @(negedge clk);
    launch(0, 2'd1, 64'd1, {32'd2, 32'd3}, {32'd4, 32'd5}, 0, 0);
    @(posedge clk); #1 launch(0, 2'd3, 64'd256, 0, 0, 6'd4, 0);
    @(posedge clk); #1 in_vld = '0;
    check("R7", 64'(out_vld[0]), 64'd1);
    check("R7", 64'(out_op[0]), 64'd1);
    check("R7", out_res[0], 64'd24);
    @(posedge clk); #1;
    check("R7", 64'(out_vld[0]), 64'd1);
    check("R7", 64'(out_op[0]), 64'd3);
    check("R7", out_res[0], 64'd16);
    @(posedge clk); #1;
    check("R7", 64'(out_vld[0]), 64'd0);
  endtask

  task automatic t_dual();
    logic [63:0] a, b, c;
    a = 64'd5; b = {32'd1, 32'd2}; c = {32'd3, 32'd4};
    @(negedge clk);
    launch(0, 2'd1, a, b, c, 0, 0);
    launch(1, 2'd3, -64'sd100, b, c, 6'd2, 1);
    @(posedge clk); #1 in_vld = '0;
    in_a = '1; in_b = '1; in_c = '1;
    @(posedge clk); #1;
    check("R8", 64'(out_vld), 64'd3);
    check("R8", out_res[0], m_dot(a, b, c));
    check("R8", out_res[1], m_shr(-64'sd100, 2, 1));
    check("R8", 64'(out_op[1]), 64'd3);
    @(negedge clk);
    launch(1, 2'd0, 64'd9, 64'h40000000, 64'h40000000, 0, 0);
    @(posedge clk); #1 in_vld = '0;
    @(posedge clk); #1;
    check("R8", 64'(out_vld), 64'd2);
    check("R8", out_res[1], 64'h20000009);
  endtask

  initial begin
    t_reset();
    t_madd();
    t_dot();
    t_pair();
    t_shift();
    t_pipe();
    t_dual();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule